// File: doc/BRIEF.md
# Latched Driver Fault Supervisor

This block supervises eight switched output channels. Each channel has raw comparator flags for overcurrent and open load. Each pair of channels shares a thermal warning flag and a thermal shutdown flag. The supply has an undervoltage flag and an overvoltage flag. The block also receives the committed serial command, which holds a per-channel enable and a per-channel open-load check enable. It receives the parallel drive inputs of channels 5 to 8, a one-cycle pulse for each accepted serial frame, and a one-cycle pulse when chip select falls. From these it computes the final gate-on level for every channel and the 16-bit status word that the serial link shifts out.

Overcurrent and open load are confirmed by a per-channel persistence counter. Each fault class then follows its own hold and release rule. Every release condition depends on the content of an accepted frame:

- An overcurrent is released by a frame that switches its channel off.
- A thermal shutdown is released by a frame that switches both channels of its pair off, and only once the over-temperature has gone.
- A supply fault is released by any frame that arrives while the supply is good.

The parallel-input levels are frozen into the status word at the moment a hard fault trips. A low on the global enable switches every output off and clears every held fault.

Top module: `drv_fault_supervisor`

## Requirements
- R1: Overcurrent and open load are confirmed only after the raw condition has held for FILT_CYCLES consecutive clocks. A shorter pulse is forgotten and the count restarts from zero.
- R2: A confirmed overcurrent holds its channel off and sets its status bit (bit 1+ch, channel ch counted from 0). An accepted frame with that channel's enable bit at 1 leaves the hold in place. An accepted frame with that enable bit at 0 releases the hold, after which a later frame can turn the channel on again.
- R3: Open load is sensed only under all of these conditions: the channel's demand is off, its open-load check enable is 1, the supply is good and the global enable is high. A confirmed open load sets status bit 1+ch and is not held: it drops as soon as the raw condition goes away.
- R4: A thermal shutdown on pair p forces channels 2p and 2p+1 off at once and sets both of their status bits.
- R5: A thermal shutdown is released only by an accepted frame whose enable bits for both channels of the pair are 0, received while the pair's shutdown flag is low.
- R6: Status bit 0 is the OR of the four thermal-warning flags. A warning does not change any gate.
- R7: Undervoltage or overvoltage forces every gate off in the same cycle and sets status bit 15. The gates return to the commanded state as soon as the supply flags drop.
- R8: Status bit 15 stays set through accepted frames that arrive while the supply is bad. It is cleared by the first accepted frame received while the supply is good.
- R9: The gate demand of channels 4 to 7 (counted from 0) is the serial enable bit ORed with parallel input bit ch-4. Channels 0 to 3 follow the serial enable only.
- R10: Status bits 9 to 12 show parallel inputs 0 to 3 live. When an overcurrent or thermal shutdown trips, the parallel levels of that clock are frozen, and the frozen value is shown while any such hold remains.
- R11: While the global enable is low, every gate is off and every held fault, counter and supply flag is cleared.
- R12: The status output is a snapshot loaded only on the chip-select-fall pulse and stable otherwise. Bits 13 and 14 are always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| glob_en_i | input | 1 | Global enable; low forces outputs off and clears holds |
| frame_ok_i | input | 1 | One-cycle pulse per accepted serial frame |
| cs_fall_i | input | 1 | One-cycle pulse on chip-select falling edge |
| cmd_on_i | input | 8 | Committed per-channel enable |
| ol_en_i | input | 8 | Committed per-channel open-load check enable |
| par_in_i | input | 4 | Parallel drive inputs for channels 4 to 7 |
| oc_raw_i | input | 8 | Raw overcurrent flags |
| ol_raw_i | input | 8 | Raw open-load flags |
| tw_raw_i | input | 4 | Raw thermal-warning flags per pair |
| tsd_raw_i | input | 4 | Raw thermal-shutdown flags per pair |
| uv_i | input | 1 | Supply undervoltage flag |
| ov_i | input | 1 | Supply overvoltage flag |
| gate_o | output | 8 | Final gate-on level per channel |
| status_o | output | 16 | Status word captured at chip-select fall |

## Verification
The hardest state to reach is a shared persistence counter that is interrupted one clock short of expiry. It must restart from zero rather than resume. The stimulus holds overcurrent for exactly FILT_CYCLES-1 clocks, drops it for one clock, and then holds it for a full FILT_CYCLES. The hold sequence for thermal shutdown also needs care: the stimulus first sends frames that would release the hold while the shutdown flag is still high or only one channel of the pair is disabled, then sends the correct release frame, and the parallel inputs are changed while a hold is active to show the frozen status bits.

// File: rtl/drv_fault_pkg.sv
package drv_fault_pkg;
  typedef enum logic {KIND_OC = 1'b0, KIND_OL = 1'b1} flt_kind_e;

  localparam int STAT_W   = 16;
  localparam int STAT_TW  = 0;
  localparam int STAT_CH0 = 1;
  localparam int STAT_SUP = 15;
endpackage

// File: rtl/drv_chan_filter.sv
module drv_chan_filter
  import drv_fault_pkg::*;
#(
  parameter int FILT_CYCLES = 100
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic gate_i,
  input  logic demand_i,
  input  logic ol_en_i,
  input  logic sup_ok_i,
  input  logic oc_raw_i,
  input  logic ol_raw_i,
  input  logic frame_i,
  input  logic cmd_on_i,
  output logic oc_latch_o,
  output logic oc_trip_o,
  output logic ol_flag_o
);
  localparam int CW = $clog2(FILT_CYCLES + 1);
  localparam logic [CW-1:0] FILT_MAX = CW'(FILT_CYCLES);

  logic [CW-1:0] cnt_q, cnt_d;
  flt_kind_e     kind_q, kind_d;
  logic          oc_cond, ol_cond, oc_q, oc_d;

  assign oc_cond = gate_i & oc_raw_i;
  assign ol_cond = ~demand_i & ol_en_i & ol_raw_i & sup_ok_i;

  always_comb begin
    kind_d = oc_cond ? KIND_OC : KIND_OL;
    if (!en_i || !(oc_cond || ol_cond))
      cnt_d = '0;
    else if (cnt_q != '0 && kind_q == kind_d)
      cnt_d = (cnt_q == FILT_MAX) ? cnt_q : cnt_q + 1'b1;
    else
      cnt_d = CW'(1);
  end

  assign oc_trip_o = oc_cond & (cnt_d == FILT_MAX);
  assign oc_d      = en_i & (oc_trip_o | (oc_q & ~(frame_i & ~cmd_on_i)));
  assign ol_flag_o = en_i & ol_cond & (cnt_q == FILT_MAX) & (kind_q == KIND_OL);
  assign oc_latch_o = oc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      kind_q <= KIND_OC;
      oc_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      kind_q <= kind_d;
      oc_q   <= oc_d;
    end
  end

  assert_oc_persist_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(oc_q) |-> ($past(oc_raw_i) && $past(gate_i)));

  assert_oc_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (oc_q && en_i && !(frame_i && !cmd_on_i)) |=> oc_q);

  assert_ol_when_off_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ol_flag_o |-> !gate_i);

  assert_en_clear_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (!oc_q && cnt_q == '0));
endmodule

// File: rtl/drv_pair_thermal.sv
module drv_pair_thermal (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  logic       tsd_raw_i,
  input  logic       frame_i,
  input  logic [1:0] cmd_pair_i,
  output logic       tsd_latch_o,
  output logic       tsd_trip_o
);
  logic tsd_q, release_ok;

  assign release_ok  = frame_i & (cmd_pair_i == 2'b00) & ~tsd_raw_i;
  assign tsd_trip_o  = en_i & tsd_raw_i & ~tsd_q;
  assign tsd_latch_o = tsd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tsd_q <= 1'b0;
    else         tsd_q <= en_i & (tsd_raw_i | (tsd_q & ~release_ok));
  end

  assert_tsd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tsd_q && (tsd_raw_i || !frame_i || cmd_pair_i != 2'b00)) |=> tsd_q);

  assert_tsd_set_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && tsd_raw_i) |=> tsd_q);
endmodule

// File: rtl/drv_supply_mon.sv
module drv_supply_mon (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic uv_i,
  input  logic ov_i,
  input  logic frame_i,
  output logic sup_ok_o,
  output logic sup_latch_o
);
  logic sup_q;

  assign sup_ok_o    = ~uv_i & ~ov_i;
  assign sup_latch_o = sup_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sup_q <= 1'b0;
    else         sup_q <= en_i & (~sup_ok_o | (sup_q & ~frame_i));
  end

  assert_sup_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && (uv_i || ov_i)) |=> sup_q);

  assert_sup_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && sup_q && !(frame_i && !uv_i && !ov_i)) |=> sup_q);
endmodule

// File: rtl/drv_status_pack.sv
module drv_status_pack
  import drv_fault_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int PAR_CH = 4
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_CH/2-1:0] tw_raw_i,
  input  logic [NUM_CH-1:0]   chan_flt_i,
  input  logic [PAR_CH-1:0]   par_in_i,
  input  logic                hard_any_i,
  input  logic                trip_any_i,
  input  logic                sup_latch_i,
  input  logic                cs_fall_i,
  output logic [STAT_W-1:0]   status_o
);
  localparam int PAR_LSB = STAT_CH0 + NUM_CH;

  logic [PAR_CH-1:0] par_frz_q, par_view;
  logic [STAT_W-1:0] live_w, snap_q;

  assign par_view = hard_any_i ? par_frz_q : par_in_i;

  always_comb begin
    live_w                      = '0;
    live_w[STAT_TW]             = |tw_raw_i;
    live_w[STAT_CH0 +: NUM_CH]  = chan_flt_i;
    live_w[PAR_LSB +: PAR_CH]   = par_view;
    live_w[STAT_SUP]            = sup_latch_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      par_frz_q <= '0;
      snap_q    <= '0;
    end else begin
      if (trip_any_i) par_frz_q <= par_in_i;
      if (cs_fall_i)  snap_q    <= live_w;
    end
  end

  assign status_o = snap_q;

  assert_par_freeze_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !trip_any_i |=> $stable(par_frz_q));

  assert_snap_stable_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_fall_i |=> $stable(status_o));
endmodule

// File: rtl/drv_fault_supervisor.sv
module drv_fault_supervisor
  import drv_fault_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int PAR_CH      = 4,
  parameter int PAR_BASE    = 4,
  parameter int FILT_CYCLES = 100
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                glob_en_i,
  input  logic                frame_ok_i,
  input  logic                cs_fall_i,
  input  logic [NUM_CH-1:0]   cmd_on_i,
  input  logic [NUM_CH-1:0]   ol_en_i,
  input  logic [PAR_CH-1:0]   par_in_i,
  input  logic [NUM_CH-1:0]   oc_raw_i,
  input  logic [NUM_CH-1:0]   ol_raw_i,
  input  logic [NUM_CH/2-1:0] tw_raw_i,
  input  logic [NUM_CH/2-1:0] tsd_raw_i,
  input  logic                uv_i,
  input  logic                ov_i,
  output logic [NUM_CH-1:0]   gate_o,
  output logic [STAT_W-1:0]   status_o
);
  localparam int NUM_PAIR = NUM_CH / 2;

  logic [NUM_CH-1:0]   demand, oc_latch, oc_trip, ol_flag, chan_flt;
  logic [NUM_PAIR-1:0] tsd_latch, tsd_trip;
  logic                sup_ok, sup_latch;

  drv_supply_mon u_sup (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (glob_en_i),
    .uv_i        (uv_i),
    .ov_i        (ov_i),
    .frame_i     (frame_ok_i),
    .sup_ok_o    (sup_ok),
    .sup_latch_o (sup_latch)
  );

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    drv_pair_thermal u_thm (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .en_i        (glob_en_i),
      .tsd_raw_i   (tsd_raw_i[p]),
      .frame_i     (frame_ok_i),
      .cmd_pair_i  (cmd_on_i[2*p +: 2]),
      .tsd_latch_o (tsd_latch[p]),
      .tsd_trip_o  (tsd_trip[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    if (c >= PAR_BASE && c < PAR_BASE + PAR_CH) begin : g_par
      assign demand[c] = cmd_on_i[c] | par_in_i[c-PAR_BASE];
    end else begin : g_ser
      assign demand[c] = cmd_on_i[c];
    end

    assign gate_o[c] = glob_en_i & sup_ok & demand[c] & ~oc_latch[c] & ~tsd_latch[c/2];
    assign chan_flt[c] = oc_latch[c] | ol_flag[c] | tsd_latch[c/2];

    drv_chan_filter #(.FILT_CYCLES(FILT_CYCLES)) u_flt (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .en_i       (glob_en_i),
      .gate_i     (gate_o[c]),
      .demand_i   (demand[c]),
      .ol_en_i    (ol_en_i[c]),
      .sup_ok_i   (sup_ok),
      .oc_raw_i   (oc_raw_i[c]),
      .ol_raw_i   (ol_raw_i[c]),
      .frame_i    (frame_ok_i),
      .cmd_on_i   (cmd_on_i[c]),
      .oc_latch_o (oc_latch[c]),
      .oc_trip_o  (oc_trip[c]),
      .ol_flag_o  (ol_flag[c])
    );

    assert_pair_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      tsd_latch[c/2] |-> !gate_o[c]);
  end

  drv_status_pack #(.NUM_CH(NUM_CH), .PAR_CH(PAR_CH)) u_stat (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tw_raw_i    (tw_raw_i),
    .chan_flt_i  (chan_flt),
    .par_in_i    (par_in_i),
    .hard_any_i  ((|oc_latch) | (|tsd_latch)),
    .trip_any_i  ((|oc_trip) | (|tsd_trip)),
    .sup_latch_i (sup_latch),
    .cs_fall_i   (cs_fall_i),
    .status_o    (status_o)
  );

  assert_supply_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (uv_i || ov_i) |-> (gate_o == '0));

  assert_en_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !glob_en_i |-> (gate_o == '0));
endmodule

// File: tb/tb_drv_fault_supervisor.sv
`timescale 1ns/1ps
module tb_drv_fault_supervisor;
  localparam int FILT = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, frame = 1'b0, cs_fall = 1'b0, uv = 1'b0, ov = 1'b0;
  logic [7:0] cmd_on = '0, ol_en = '0, oc_raw = '0, ol_raw = '0;
  logic [3:0] par_in = '0, tw_raw = '0, tsd_raw = '0;
  logic [7:0]  gate;
  logic [15:0] status;

  int n_tests = 0, n_fail = 0;
  bit done = 1'b0;
  string cur_req = "reset";

  always #4 clk = ~clk;

  drv_fault_supervisor #(.FILT_CYCLES(FILT)) dut (
    .clk_i(clk), .rst_ni(rst_n), .glob_en_i(en), .frame_ok_i(frame),
    .cs_fall_i(cs_fall), .cmd_on_i(cmd_on), .ol_en_i(ol_en), .par_in_i(par_in),
    .oc_raw_i(oc_raw), .ol_raw_i(ol_raw), .tw_raw_i(tw_raw), .tsd_raw_i(tsd_raw),
    .uv_i(uv), .ov_i(ov), .gate_o(gate), .status_o(status)
  );

  // reference model state
  int          m_cnt [8];
  bit          m_kind [8];
  bit          m_oc [8];
  bit          m_tsd [4];
  bit          m_sup;
  logic [3:0]  m_frz;
  logic [15:0] m_rep;

  function automatic bit m_dem(int c);
    return cmd_on[c] || ((c >= 4) ? par_in[c%4] : 1'b0);
  endfunction

  function automatic bit m_gate(int c);
    return en && !uv && !ov && m_dem(c) && !m_oc[c] && !m_tsd[c/2];
  endfunction

  function automatic bit m_olc(int c);
    return !m_dem(c) && ol_en[c] && ol_raw[c] && !uv && !ov;
  endfunction

  function automatic logic [7:0] m_gates();
    logic [7:0] g;
    for (int c = 0; c < 8; c++) g[c] = m_gate(c);
    return g;
  endfunction

  function automatic logic [15:0] m_word();
    logic [15:0] w = '0;
    bit hard = 0;
    w[0] = |tw_raw;
    for (int c = 0; c < 8; c++) begin
      bit olf;
      olf = en && m_olc(c) && m_cnt[c] == FILT && m_kind[c];
      w[1+c] = m_oc[c] || olf || m_tsd[c/2];
      if (m_oc[c]) hard = 1;
    end
    for (int p = 0; p < 4; p++) if (m_tsd[p]) hard = 1;
    w[12:9] = hard ? m_frz : par_in;
    w[15] = m_sup;
    return w;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int c = 0; c < 8; c++) begin m_cnt[c] = 0; m_kind[c] = 0; m_oc[c] = 0; end
      for (int p = 0; p < 4; p++) m_tsd[p] = 0;
      m_sup = 0; m_frz = '0; m_rep = '0;
    end else begin
      logic [15:0] w;
      logic [7:0] g;
      bit trip;
      w = m_word();
      g = m_gates();
      trip = 0;
      for (int c = 0; c < 8; c++) begin
        bit occ, olc, k;
        int n;
        occ = g[c] && oc_raw[c];
        olc = m_olc(c);
        k = !occ;
        if (!en || !(occ || olc)) n = 0;
        else if (m_cnt[c] != 0 && m_kind[c] == k) n = (m_cnt[c] < FILT) ? m_cnt[c] + 1 : FILT;
        else n = 1;
        if (occ && n == FILT) trip = 1;
        m_oc[c] = en && ((occ && n == FILT) || (m_oc[c] && !(frame && !cmd_on[c])));
        m_cnt[c] = n;
        m_kind[c] = k;
      end
      for (int p = 0; p < 4; p++) begin
        if (en && tsd_raw[p] && !m_tsd[p]) trip = 1;
        m_tsd[p] = en && (tsd_raw[p] ||
                   (m_tsd[p] && !(frame && !cmd_on[2*p] && !cmd_on[2*p+1])));
      end
      if (trip) m_frz = par_in;
      m_sup = en && (uv || ov || (m_sup && !frame));
      if (cs_fall) m_rep = w;
    end
  end

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // every-cycle comparison against the model
  always @(negedge clk) begin
    #1;
    if (rst_n && !done) begin
      chk({cur_req, " gate"}, {8'h00, gate}, {8'h00, m_gates()});
      chk({cur_req, " status"}, status, m_rep);
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] c);
    cmd_on = c; frame = 1'b1;
    tick(1);
    frame = 1'b0;
  endtask

  task automatic snap();
    cs_fall = 1'b1;
    tick(1);
    cs_fall = 1'b0;
  endtask

  task automatic expect_gate(input string req, input logic [7:0] exp);
    #2 chk(req, {8'h00, gate}, {8'h00, exp});
  endtask

  task automatic expect_stat(input string req, input logic [15:0] exp);
    #2 chk(req, status, exp);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    cur_req = "R11 reset";
    expect_gate("R11 reset gate", 8'h00);
    expect_stat("R12 reset status", 16'h0000);
    en = 1'b1;
    tick(1);

    cur_req = "R9";
    send_frame(8'h0F);
    expect_gate("R9 serial only", 8'h0F);
    par_in = 4'b1010; tick(1);
    expect_gate("R9 parallel OR", 8'hAF);
    par_in = 4'b0000; tick(1);
    expect_gate("R9 parallel released", 8'h0F);
    send_frame(8'h00);

    cur_req = "R1";
    send_frame(8'h01);
    oc_raw[0] = 1'b1; tick(FILT - 1);
    expect_gate("R1 short overcurrent ignored", 8'h01);
    oc_raw[0] = 1'b0; tick(1);
    oc_raw[0] = 1'b1; par_in = 4'b1010; tick(1);
    tick(FILT - 1);
    expect_gate("R1 overcurrent confirmed", 8'hA0);

    cur_req = "R10";
    oc_raw[0] = 1'b0;
    par_in = 4'b0101; tick(1);
    expect_gate("R2 channel held off", 8'h50);
    snap();
    expect_stat("R10 frozen parallel bits", 16'h1402);

    cur_req = "R2";
    send_frame(8'h01);
    expect_gate("R2 enable frame keeps hold", 8'h50);
    send_frame(8'h00);
    send_frame(8'h01);
    expect_gate("R2 released then re-enabled", 8'h51);
    snap();
    expect_stat("R10 live parallel bits", 16'h0A00);
    par_in = 4'b0000;
    send_frame(8'h00);

    cur_req = "R3";
    ol_en = 8'h04; ol_raw[2] = 1'b1; tick(FILT);
    snap();
    expect_stat("R3 open load reported", 16'h0008);
    ol_raw[2] = 1'b0; tick(1);
    snap();
    expect_stat("R3 open load not held", 16'h0000);
    ol_en = 8'h00; ol_raw[2] = 1'b1; tick(FILT);
    snap();
    expect_stat("R3 check disabled ignored", 16'h0000);
    ol_en = 8'h04;
    send_frame(8'h04); tick(FILT);
    snap();
    expect_stat("R3 channel on ignored", 16'h0000);
    ol_raw = '0; ol_en = '0;
    send_frame(8'h00);

    cur_req = "R4";
    send_frame(8'h0C);
    expect_gate("R4 pair running", 8'h0C);
    tsd_raw[1] = 1'b1; tick(1);
    expect_gate("R4 pair shut down", 8'h00);
    snap();
    expect_stat("R4 both status bits", 16'h0018);

    cur_req = "R5";
    send_frame(8'h00);
    send_frame(8'h0C);
    expect_gate("R5 hot release refused", 8'h00);
    tsd_raw[1] = 1'b0;
    send_frame(8'h04);
    expect_gate("R5 half pair release refused", 8'h00);
    send_frame(8'h00);
    send_frame(8'h0C);
    expect_gate("R5 pair released", 8'h0C);

    cur_req = "R6";
    tw_raw = 4'b0100; tick(1);
    expect_gate("R6 warning keeps outputs", 8'h0C);
    snap();
    expect_stat("R6 warning bit", 16'h0001);
    tw_raw = '0;

    cur_req = "R7";
    uv = 1'b1; tick(1);
    expect_gate("R7 undervoltage off", 8'h00);
    uv = 1'b0; tick(1);
    expect_gate("R7 recovery", 8'h0C);
    snap();
    expect_stat("R7 supply bit held", 16'h8000);

    cur_req = "R8";
    ov = 1'b1;
    send_frame(8'h0C);
    expect_gate("R7 overvoltage off", 8'h00);
    ov = 1'b0; tick(1);
    snap();
    expect_stat("R8 frame during fault keeps bit", 16'h8000);
    send_frame(8'h0C);
    snap();
    expect_stat("R8 cleared by good frame", 16'h0000);

    cur_req = "R11";
    oc_raw[2] = 1'b1; tick(FILT);
    expect_gate("R11 overcurrent before disable", 8'h08);
    en = 1'b0; tick(1);
    expect_gate("R11 disable forces off", 8'h00);
    oc_raw[2] = 1'b0; en = 1'b1; tick(1);
    expect_gate("R11 holds cleared", 8'h0C);

    cur_req = "R12";
    tw_raw = 4'b0001; tick(3);
    expect_stat("R12 no capture without pulse", 16'h0000);
    snap();
    expect_stat("R12 capture on pulse", 16'h0001);
    #1 chk("R12 pad bits zero", {14'd0, status[14:13]}, 16'h0000);
    tw_raw = '0;
    tick(2);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule